// File: doc/BRIEF.md
# Masked Bit-Field Manipulation Unit

This block performs read-modify-write operations on a 16-bit word under a 16-bit mask. A word read from data memory, a peripheral register or a core register is presented together with a mask and an operation code. The unit can set, clear or invert the masked bits, or test them. Test operations update a condition flag and never request a write-back. Modify operations produce a result word and raise a write-back strobe for exactly one cycle. A byte-lane mode supports branch-on-bit-field use: it places an 8-bit mask in either the upper or the lower byte, so at most eight bits are examined.

The same unit also contains a combinational transfer switch between three 16-bit data buses (core, program and peripheral). The switch copies the selected source bus onto the selected destination bus in the same cycle, with no register in the path. When the source is a register narrower than the bus, the switch forces the unused upper bits to zero. A selection that names the same bus twice, or names no bus, drives nothing and raises an error.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `wr_strobe` and `cond_flag` are 0 after that edge.
- R2: Set (`op_code` 2), accepted with `op_valid`, gives `result = operand | emask` after the next edge. Unmasked bits pass through unchanged.
- R3: Clear (`op_code` 3) gives `result = operand & ~emask` after the next edge.
- R4: Invert (`op_code` 4) gives `result = operand ^ emask` after the next edge.
- R5: Test-ones (`op_code` 0) sets `cond_flag` when every bit of `emask` is 1 in `operand`. Test-zeros (`op_code` 1) sets it when every bit of `emask` is 0 in `operand`. An all-zero `emask` makes either test true. After a test, `result` equals `operand` and `wr_strobe` stays 0.
- R6: When `lane_mode` is 1, `emask` is `mask[7:0]` placed in bits 15:8 if `lane_hi` is 1, or in bits 7:0 otherwise. `mask[15:8]` is ignored, and the other lane of `operand` neither affects the flag nor changes in `result`. When `lane_mode` is 0, `emask = mask`.
- R7: `cond_flag` changes only after an accepted test. `result` holds while `op_valid` is 0.
- R8: Op codes 5, 6 and 7 are no-ops: no strobe, and `result` and `cond_flag` hold.
- R9: `wr_strobe` is 1 for exactly the one cycle after each accepted set, clear or invert, and is 0 at all other times.
- R10: With `xfer_en` high, source `src_sel` and destination `dst_sel` (0 = core, 1 = program, 2 = peripheral) distinct and both below 3, the destination output equals the source input in the same cycle. `bus_drive` then has only the destination bit set, and every other bus output is 0.
- R11: With `xfer_en` high and `src_sel == dst_sel`, or either select equal to 3, no bus is driven (`bus_drive` = 0, all bus outputs 0) and `xfer_err` is 1. With `xfer_en` low, `xfer_err` is 0 and nothing is driven.
- R12: When `xfer_bits` is between 1 and 15, bits at and above position `xfer_bits` of the transferred word read as 0. A value of 0, or 16 and above, passes all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 test-ones, 1 test-zeros, 2 set, 3 clear, 4 invert |
| mask | input | 16 | Bit mask (only bits 7:0 used in lane mode) |
| lane_mode | input | 1 | Restrict the mask to one byte lane |
| lane_hi | input | 1 | Lane select: 1 upper byte, 0 lower byte |
| operand | input | 16 | Word to operate on |
| result | output | 16 | Registered result word |
| wr_strobe | output | 1 | Write-back request, one cycle |
| cond_flag | output | 1 | Registered outcome of the last test |
| xfer_en | input | 1 | Request a bus transfer |
| src_sel | input | 2 | Source bus select |
| dst_sel | input | 2 | Destination bus select |
| xfer_bits | input | 5 | Valid width of the source register (0 = full) |
| core_bus_in | input | 16 | Core bus value |
| prog_bus_in | input | 16 | Program bus value |
| peri_bus_in | input | 16 | Peripheral bus value |
| core_bus_out | output | 16 | Value driven onto the core bus |
| prog_bus_out | output | 16 | Value driven onto the program bus |
| peri_bus_out | output | 16 | Value driven onto the peripheral bus |
| bus_drive | output | 3 | Per-bus drive enable (bit 0 core, 1 program, 2 peripheral) |
| xfer_err | output | 1 | Illegal transfer selection |

## Verification
The bench places junk in the ignored upper mask byte during lane-mode operations. A design that decodes those bits would flip or test bits in the wrong lane. It runs tests with an all-zero mask, where a design that tests "any bit" instead of "every bit" reports false. It sends the unused op codes, which a loose decoder would turn into spurious write-backs or changes to the flag. It also issues back-to-back modify operations, where a strobe that is stretched or merged shows up as a count mismatch. On the bus side it covers all six legal pairs, self-selection and the idle select code, and width limits of 0, 4, 15, 16 and above. A switch that drives a bus on an illegal select, or that zero-extends at the wrong boundary, therefore shows on the outputs in the same cycle.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    OP_TST_ONES  = 3'd0,
    OP_TST_ZEROS = 3'd1,
    OP_SET       = 3'd2,
    OP_CLR       = 3'd3,
    OP_INV       = 3'd4
  } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] mask,
  input  logic         lane_mode,
  input  logic         lane_hi,
  output logic [W-1:0] emask
);
  localparam int LW = W / 2;

  always_comb begin
    if (!lane_mode)
      emask = mask;
    else if (lane_hi)
      emask = {mask[LW-1:0], {(W-LW){1'b0}}};
    else
      emask = {{(W-LW){1'b0}}, mask[LW-1:0]};
  end
endmodule

// File: rtl/bfu_alu.sv
module bfu_alu
  import bfu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] emask,
  output logic [W-1:0] new_word,
  output logic         hit,
  output logic         is_test,
  output logic         is_modify
);
  logic [W-1:0] picked;
  assign picked = operand & emask;

  always_comb begin
    new_word  = operand;
    hit       = 1'b0;
    is_test   = 1'b0;
    is_modify = 1'b0;
    case (op_code)
      OP_TST_ONES:  begin is_test = 1'b1; hit = (picked == emask); end
      OP_TST_ZEROS: begin is_test = 1'b1; hit = (picked == '0); end
      OP_SET:       begin is_modify = 1'b1; new_word = operand | emask; end
      OP_CLR:       begin is_modify = 1'b1; new_word = operand & ~emask; end
      OP_INV:       begin is_modify = 1'b1; new_word = operand ^ emask; end
      default:      ;
    endcase
  end
endmodule

// File: rtl/bfu_bus_switch.sv
module bfu_bus_switch #(
  parameter int W    = 16,
  parameter int NBUS = 3,
  parameter int SW   = 2,
  parameter int CW   = 5
) (
  input  logic                     en,
  input  logic [SW-1:0]            src_sel,
  input  logic [SW-1:0]            dst_sel,
  input  logic [CW-1:0]            width_lim,
  input  logic [NBUS-1:0][W-1:0]   bus_in,
  output logic [NBUS-1:0][W-1:0]   bus_out,
  output logic [NBUS-1:0]          drive,
  output logic                     err
);
  logic         full;
  logic         legal;
  logic [W-1:0] keep;
  logic [W-1:0] src_word;

  assign full  = (width_lim == '0) || (width_lim >= CW'(W));
  assign legal = en && (src_sel < SW'(NBUS)) && (dst_sel < SW'(NBUS)) &&
                 (src_sel != dst_sel);
  assign err   = en && !legal;

  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = full || (CW'(i) < width_lim);
  end

  always_comb begin
    src_word = '0;
    for (int k = 0; k < NBUS; k++)
      if (src_sel == SW'(k)) src_word = bus_in[k];
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign drive[b]   = legal && (dst_sel == SW'(b));
    assign bus_out[b] = drive[b] ? (src_word & keep) : '0;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int W    = 16,
  parameter int NBUS = 3,
  localparam int SW  = 2,
  localparam int CW  = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [W-1:0]  mask,
  input  logic          lane_mode,
  input  logic          lane_hi,
  input  logic [W-1:0]  operand,
  output logic [W-1:0]  result,
  output logic          wr_strobe,
  output logic          cond_flag,
  input  logic          xfer_en,
  input  logic [SW-1:0] src_sel,
  input  logic [SW-1:0] dst_sel,
  input  logic [CW-1:0] xfer_bits,
  input  logic [W-1:0]  core_bus_in,
  input  logic [W-1:0]  prog_bus_in,
  input  logic [W-1:0]  peri_bus_in,
  output logic [W-1:0]  core_bus_out,
  output logic [W-1:0]  prog_bus_out,
  output logic [W-1:0]  peri_bus_out,
  output logic [NBUS-1:0] bus_drive,
  output logic          xfer_err
);
  logic [W-1:0] emask, new_word;
  logic         hit, is_test, is_modify;
  logic [W-1:0] result_q;
  logic         strobe_q, flag_q;
  logic [NBUS-1:0][W-1:0] bin, bout;

  bfu_mask_gen #(.W(W)) u_mask (
    .mask(mask), .lane_mode(lane_mode), .lane_hi(lane_hi), .emask(emask)
  );

  bfu_alu #(.W(W)) u_alu (
    .op_code(op_code), .operand(operand), .emask(emask),
    .new_word(new_word), .hit(hit), .is_test(is_test), .is_modify(is_modify)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      strobe_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (op_valid && (is_test || is_modify)) begin
        result_q <= new_word;
        strobe_q <= is_modify;
        if (is_test) flag_q <= hit;
      end
    end
  end

  assign result    = result_q;
  assign wr_strobe = strobe_q;
  assign cond_flag = flag_q;

  assign bin = {peri_bus_in, prog_bus_in, core_bus_in};

  bfu_bus_switch #(.W(W), .NBUS(NBUS), .SW(SW), .CW(CW)) u_switch (
    .en(xfer_en), .src_sel(src_sel), .dst_sel(dst_sel), .width_lim(xfer_bits),
    .bus_in(bin), .bus_out(bout), .drive(bus_drive), .err(xfer_err)
  );

  assign core_bus_out = bout[0];
  assign prog_bus_out = bout[1];
  assign peri_bus_out = bout[2];

  // R2: every masked bit is 1 after a full-width set
  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SET && !lane_mode) |=> ((result & $past(mask)) == $past(mask)));

  // R3: every masked bit is 0 after a full-width clear
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CLR && !lane_mode) |=> ((result & $past(mask)) == '0));

  // R5: tests never request write-back
  a_r5_test_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_TST_ONES || op_code == OP_TST_ZEROS)) |=> !wr_strobe);

  // R7: the flag moves only after an accepted test
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && (op_code == OP_TST_ONES || op_code == OP_TST_ZEROS)) |=> $stable(cond_flag));

  // R8: idle cycles and unused codes leave the result alone
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code > 3'd4) |=> $stable(result));

  // R9: a strobe is always caused by an operation in the cycle before
  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $past(op_valid));

  // R10: at most one bus driven
  a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_drive));

  // R11: an illegal selection drives nothing
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (rst)
    xfer_err |-> (bus_drive == '0));
endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [15:0] mask = '0, operand = '0;
  logic        lane_mode = 1'b0, lane_hi = 1'b0;
  logic [15:0] result;
  logic        wr_strobe, cond_flag;
  logic        xfer_en = 1'b0;
  logic [1:0]  src_sel = '0, dst_sel = '0;
  logic [4:0]  xfer_bits = '0;
  logic [15:0] core_in = '0, prog_in = '0, peri_in = '0;
  logic [15:0] core_out, prog_out, peri_out;
  logic [2:0]  bus_drive;
  logic        xfer_err;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitfield_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .mask(mask),
    .lane_mode(lane_mode), .lane_hi(lane_hi), .operand(operand),
    .result(result), .wr_strobe(wr_strobe), .cond_flag(cond_flag),
    .xfer_en(xfer_en), .src_sel(src_sel), .dst_sel(dst_sel), .xfer_bits(xfer_bits),
    .core_bus_in(core_in), .prog_bus_in(prog_in), .peri_bus_in(peri_in),
    .core_bus_out(core_out), .prog_bus_out(prog_out), .peri_bus_out(peri_out),
    .bus_drive(bus_drive), .xfer_err(xfer_err)
  );

  // reference model state
  logic [15:0] m_res = '0;
  logic        m_stb = 1'b0, m_flag = 1'b0;
  string       m_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_res = '0; m_stb = 1'b0; m_flag = 1'b0; m_tag = "R1";
    end else begin
      m_stb = 1'b0;
      m_tag = "R7";
      if (op_valid) begin
        logic [15:0] em;
        bit all1, all0;
        for (int i = 0; i < 16; i++) begin
          if (!lane_mode) em[i] = mask[i];
          else if (lane_hi) em[i] = (i >= 8) ? mask[i-8] : 1'b0;
          else em[i] = (i < 8) ? mask[i] : 1'b0;
        end
        all1 = 1; all0 = 1;
        for (int i = 0; i < 16; i++) if (em[i]) begin
          if (!operand[i]) all1 = 0;
          if (operand[i])  all0 = 0;
        end
        case (op_code)
          3'd0: begin m_res = operand; m_flag = all1; m_tag = "R5"; end
          3'd1: begin m_res = operand; m_flag = all0; m_tag = "R5"; end
          3'd2: begin m_res = operand | em;  m_stb = 1; m_tag = "R2"; end
          3'd3: begin m_res = operand & ~em; m_stb = 1; m_tag = "R3"; end
          3'd4: begin m_res = operand ^ em;  m_stb = 1; m_tag = "R4"; end
          default: m_tag = "R8";
        endcase
        if (lane_mode && op_code <= 3'd4) m_tag = "R6";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] keep, src, exp_o [3];
      logic [2:0]  exp_d;
      bit legal;
      string btag;
      chk(m_tag, result, m_res);
      chk((m_tag == "R1") ? "R1" : "R9", wr_strobe, m_stb);
      chk((m_tag == "R5" || m_tag == "R6" || m_tag == "R1") ? m_tag : "R7", cond_flag, m_flag);
      legal = xfer_en && src_sel != 2'd3 && dst_sel != 2'd3 && src_sel != dst_sel;
      for (int i = 0; i < 16; i++)
        keep[i] = (xfer_bits == 0 || xfer_bits >= 16 || i < xfer_bits);
      src = (src_sel == 0) ? core_in : (src_sel == 1) ? prog_in : peri_in;
      for (int b = 0; b < 3; b++) begin
        exp_d[b] = legal && dst_sel == b;
        exp_o[b] = exp_d[b] ? (src & keep) : 16'h0;
      end
      btag = (xfer_bits != 0 && xfer_bits < 16) ? "R12" : "R10";
      chk(btag, core_out, exp_o[0]);
      chk(btag, prog_out, exp_o[1]);
      chk(btag, peri_out, exp_o[2]);
      chk("R10", bus_drive, exp_d);
      chk("R11", xfer_err, xfer_en && !legal);
    end
  end

  task automatic do_op(input logic [2:0] c, input logic [15:0] m, input logic lm,
                       input logic lh, input logic [15:0] opd);
    @(posedge clk); #1;
    op_valid = 1; op_code = c; mask = m; lane_mode = lm; lane_hi = lh; operand = opd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; op_valid = 0; operand = $urandom; op_code = $urandom;
    end
  endtask

  task automatic xfer(input logic en, input logic [1:0] s, input logic [1:0] d,
                      input logic [4:0] nb);
    @(posedge clk); #1;
    xfer_en = en; src_sel = s; dst_sel = d; xfer_bits = nb;
    core_in = $urandom; prog_in = $urandom; peri_in = $urandom;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2 R3 R4 directed, including back-to-back (R9)
    do_op(3'd2, 16'h00F0, 0, 0, 16'h1203);
    do_op(3'd3, 16'h0F0F, 0, 0, 16'hFFFF);
    do_op(3'd4, 16'hA5A5, 0, 0, 16'h0FF0);
    idle(2);
    // R5 tests, true/false and zero mask
    do_op(3'd0, 16'h8001, 0, 0, 16'h8001);
    do_op(3'd0, 16'h8001, 0, 0, 16'h8000);
    do_op(3'd1, 16'h0110, 0, 0, 16'hFEEF);
    do_op(3'd1, 16'h0110, 0, 0, 16'h0100);
    do_op(3'd0, 16'h0000, 0, 0, 16'h0000);
    do_op(3'd1, 16'h0000, 0, 0, 16'hFFFF);
    // R6 lane mode with junk in mask upper byte
    do_op(3'd0, 16'hFF81, 1, 0, 16'h0081);
    do_op(3'd1, 16'hFF81, 1, 1, 16'h7E00);
    do_op(3'd2, 16'h3C0F, 1, 1, 16'h0000);
    do_op(3'd4, 16'hF0FF, 1, 0, 16'h1234);
    do_op(3'd0, 16'hFF01, 1, 1, 16'h00FF);
    // R8 unused codes
    do_op(3'd5, 16'hFFFF, 0, 0, 16'h5555);
    do_op(3'd6, 16'hFFFF, 0, 0, 16'h5555);
    do_op(3'd7, 16'hFFFF, 0, 0, 16'h5555);
    idle(3);
    // R10 all legal pairs, R11 illegal, R12 widths
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++) xfer(1, 2'(s), 2'(d), 5'd0);
    xfer(1, 2'd3, 2'd1, 5'd0);
    xfer(1, 2'd0, 2'd3, 5'd0);
    xfer(0, 2'd0, 2'd1, 5'd0);
    xfer(1, 2'd1, 2'd2, 5'd4);
    xfer(1, 2'd2, 2'd0, 5'd15);
    xfer(1, 2'd0, 2'd2, 5'd16);
    xfer(1, 2'd2, 2'd1, 5'd20);
    xfer(1, 2'd1, 2'd0, 5'd1);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      op_valid = $urandom_range(0, 1); op_code = $urandom; mask = $urandom;
      if (($urandom & 7) == 0) mask = 16'h0;
      lane_mode = $urandom_range(0, 1); lane_hi = $urandom_range(0, 1); operand = $urandom;
      xfer_en = $urandom_range(0, 1); src_sel = $urandom; dst_sel = $urandom;
      xfer_bits = $urandom; core_in = $urandom; prog_in = $urandom; peri_in = $urandom;
    end
    idle(2);
    // R1 reset returns outputs to zero
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1;
    @(posedge clk); #1 rst = 0;
    idle(2);
    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule